// File: doc/BRIEF.md
# Programmable-Threshold FIFO with Fall-Through Output

This block is a first-in first-out buffer built around an inferred dual-port memory. It keeps its own write and read addresses, which advance on every accepted transfer. It reports full, empty, almost-full and almost-empty status. Each almost threshold is taken from a level input, so software or neighbouring logic can change it while the buffer runs. The write and read data ports always have the same width.

The `fwft_mode` input chooses how the read side presents data. In standard mode a read strobe fetches the oldest word, and that word appears on the read data port one cycle later. In fall-through mode the oldest word is moved into the output register ahead of time and shown with `rd_valid` before any read is issued. A read strobe then consumes that word. Once the first word has been consumed, the two modes deliver data in the same order and at the same rate.

The `ASYNC` parameter selects the clocking. When it is 0, a single clock drives both sides. When it is 1, the two sides run on independent clocks. Each pointer then crosses to the other side as a Gray code through two flip-flop stages, full is computed on the write side and empty on the read side. A write while full and a read with nothing to deliver are both ignored, and each sets its own sticky error bit. The mode input is expected to change only while reset is held.

Top module: `fwft_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it is released, empty is 1, full is 0, rd_valid is 0, and both overflow and underflow are 0.
- R2: full is 1 exactly when the memory holds DEPTH words. A write while full stores nothing and sets overflow, which stays 1 until reset.
- R3: In standard mode (fwft_mode = 0), a read strobe while not empty puts the oldest stored word on rd_data. That word is valid in the cycle after the strobe, and rd_valid is 1 for that one cycle.
- R4: A read strobe with no word to deliver changes no stored data and sets underflow, which stays 1 until reset. "No word to deliver" means memory empty in standard mode, or rd_valid = 0 in fall-through mode.
- R5: In fall-through mode (fwft_mode = 1), a word written into an empty buffer appears on rd_data with rd_valid = 1 one cycle after the write edge, with no read strobe. empty stays 1 until that moment.
- R6: In fall-through mode, a read strobe while rd_valid is 1 consumes the shown word. If another word is stored, it is shown in the next cycle. If not, rd_valid falls and empty rises. Without a strobe, the shown word and rd_valid hold.
- R7: In fall-through mode, the output register holds one word on top of the DEPTH words in memory. full reflects the memory alone.
- R8: almost_full is 1 exactly when the number of words in memory is greater than or equal to af_level. A change to af_level takes effect in the same cycle.
- R9: almost_empty is 1 exactly when the number of words visible to the reader is at most ae_level. The visible count is the memory count, plus the shown word in fall-through mode. A change to ae_level takes effect in the same cycle.
- R10: With a single clock in standard mode, empty falls in the cycle right after the edge that wrote into an empty buffer.
- R11: Words leave in exactly the order they were accepted, including across address wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; also the only clock when ASYNC = 0 |
| rd_clk | input | 1 | Read-side clock, used only when ASYNC = 1 |
| rst | input | 1 | Synchronous active-high reset for both sides |
| fwft_mode | input | 1 | 0 = standard read, 1 = fall-through read |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| af_level | input | $clog2(DEPTH)+1 | Almost-full threshold |
| full | output | 1 | Memory holds DEPTH words |
| almost_full | output | 1 | Memory count is at least af_level |
| overflow | output | 1 | Sticky: a write was attempted while full |
| rd_en | input | 1 | Read strobe |
| ae_level | input | $clog2(DEPTH)+1 | Almost-empty threshold |
| rd_data | output | WIDTH | Read data |
| rd_valid | output | 1 | rd_data holds a delivered word |
| empty | output | 1 | No word available to the reader |
| almost_empty | output | 1 | Visible count is at most ae_level |
| underflow | output | 1 | Sticky: a read was attempted with nothing to deliver |

## Verification
A read or write pointer that is off by one shows up quickly at the ports. Either full or empty takes the wrong value, or rd_data returns a word out of order at the next delivery, usually within a cycle or two of the fault. A lost or duplicated fall-through valid bit shows as rd_valid or empty disagreeing with the count of accepted writes. This happens in the cycle after the first write into an empty buffer, or right after the strobe that consumes the last word. A wrong count comparison shows as almost_full or almost_empty being wrong in the same cycle that a threshold level or the fill level crosses it.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic overflow;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
        logic underflow;
    } rd_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fwft_fifo_ram.sv
module fwft_fifo_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clk,
    input  logic             rst,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/fwft_fifo_sync.sv
module fwft_fifo_sync #(
    parameter int W     = 5,
    parameter int ASYNC = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (ASYNC != 0) begin : g_two_stage
            logic [W-1:0] stage1, stage2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1 <= '0;
                    stage2 <= '0;
                end else begin
                    stage1 <= d;
                    stage2 <= stage1;
                end
            end
            assign q = stage2;
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/fwft_fifo_wr.sv
module fwft_fifo_wr
    import fwft_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_gray_s,
    input  logic [PW-1:0] af_level,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wr_gray,
    output wr_flags_t     flags
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [PW-1:0] wr_bin, wr_bin_n, rd_bin, used;
    logic          ovf_q;

    always_comb begin
        rd_bin            = PW'(gray2bin(32'(rd_gray_s)));
        used              = wr_bin - rd_bin;
        flags.full        = (used == FULL_CNT);
        flags.almost_full = (used >= af_level);
        flags.overflow    = ovf_q;
        we                = wr_en & ~flags.full;
        wr_bin_n          = wr_bin + PW'(we);
        waddr             = wr_bin[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            ovf_q   <= 1'b0;
        end else begin
            wr_bin  <= wr_bin_n;
            wr_gray <= PW'(bin2gray(32'(wr_bin_n)));
            if (wr_en && flags.full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assert_full_blocks_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flags.full) |=> (wr_bin == $past(wr_bin)));
    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        flags.overflow |=> flags.overflow);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        used <= FULL_CNT);
endmodule

// File: rtl/fwft_fifo_rd.sv
module fwft_fifo_rd
    import fwft_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          fwft_mode,
    input  logic [PW-1:0] wr_gray_s,
    input  logic [PW-1:0] ae_level,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rd_gray,
    output logic          rd_valid,
    output rd_flags_t     flags
);
    rd_mode_e      mode;
    logic [PW-1:0] rd_bin, rd_bin_n, wr_bin, stored, visible;
    logic          mem_empty, valid_q, valid_n, unf_q, underrun;

    always_comb begin
        mode      = rd_mode_e'(fwft_mode);
        wr_bin    = PW'(gray2bin(32'(wr_gray_s)));
        stored    = wr_bin - rd_bin;
        mem_empty = (stored == '0);
        case (mode)
            MODE_FWFT: begin
                re          = ~mem_empty & (~valid_q | rd_en);
                valid_n     = re | (valid_q & ~rd_en);
                underrun    = rd_en & ~valid_q;
                flags.empty = ~valid_q;
                visible     = stored + PW'(valid_q);
            end
            default: begin
                re          = rd_en & ~mem_empty;
                valid_n     = re;
                underrun    = rd_en & mem_empty;
                flags.empty = mem_empty;
                visible     = stored;
            end
        endcase
        flags.almost_empty = (visible <= ae_level);
        flags.underflow    = unf_q;
        rd_bin_n           = rd_bin + PW'(re);
        raddr              = rd_bin[AW-1:0];
        rd_valid           = valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            valid_q <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            rd_bin  <= rd_bin_n;
            rd_gray <= PW'(bin2gray(32'(rd_bin_n)));
            valid_q <= valid_n;
            if (underrun) begin
                unf_q <= 1'b1;
            end
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mem_empty) |=> (rd_bin == $past(rd_bin)));
    assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        flags.underflow |=> flags.underflow);
    assert_fwft_valid_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && valid_q && !rd_en) |=> valid_q);
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
    import fwft_fifo_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    parameter int ASYNC = 0
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst,
    input  logic                     fwft_mode,
    input  logic                     wr_en,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH):0]   af_level,
    output logic                     full,
    output logic                     almost_full,
    output logic                     overflow,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH):0]   ae_level,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     rd_valid,
    output logic                     empty,
    output logic                     almost_empty,
    output logic                     underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          rd_clk_i;
    logic          we, re;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    assign rd_clk_i = (ASYNC != 0) ? rd_clk : wr_clk;

    fwft_fifo_sync #(.W(PW), .ASYNC(ASYNC)) u_rd2wr (
        .clk(wr_clk), .rst(rst), .d(rd_gray), .q(rd_gray_s)
    );
    fwft_fifo_sync #(.W(PW), .ASYNC(ASYNC)) u_wr2rd (
        .clk(rd_clk_i), .rst(rst), .d(wr_gray), .q(wr_gray_s)
    );

    fwft_fifo_wr #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
        .af_level(af_level), .we(we), .waddr(waddr), .wr_gray(wr_gray),
        .flags(wflags)
    );

    fwft_fifo_rd #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk_i), .rst(rst), .rd_en(rd_en), .fwft_mode(fwft_mode),
        .wr_gray_s(wr_gray_s), .ae_level(ae_level), .re(re), .raddr(raddr),
        .rd_gray(rd_gray), .rd_valid(rd_valid), .flags(rflags)
    );

    fwft_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk_i), .rst(rst), .re(re), .raddr(raddr), .q(rd_data)
    );

    assign full         = wflags.full;
    assign almost_full  = wflags.almost_full;
    assign overflow     = wflags.overflow;
    assign empty        = rflags.empty;
    assign almost_empty = rflags.almost_empty;
    assign underflow    = rflags.underflow;

    assert_fwft_data_hold_R6: assert property (@(posedge rd_clk_i) disable iff (rst)
        (fwft_mode && rd_valid && !rd_en) |=> $stable(rd_data));
    assert_valid_not_empty_R5: assert property (@(posedge rd_clk_i) disable iff (rst)
        (fwft_mode && rd_valid) |-> !empty);
endmodule

// File: tb/fwft_fifo_bench.sv
module fwft_fifo_bench;
    localparam int WIDTH = 16;
    localparam int DEPTH = 16;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fwft_mode = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [PW-1:0]    af_level = PW'(12), ae_level = PW'(2);
    logic             full, almost_full, overflow, rd_valid, empty, almost_empty, underflow;
    logic [WIDTH-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [WIDTH-1:0] mq[$];
    bit               m_vld, m_ovf, m_unf;
    logic [WIDTH-1:0] m_od;

    always #5 clk = ~clk;

    fwft_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ASYNC(0)) u_fwft_fifo (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .wr_data(wr_data), .af_level(af_level),
        .full(full), .almost_full(almost_full), .overflow(overflow),
        .rd_en(rd_en), .ae_level(ae_level), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty(empty), .almost_empty(almost_empty),
        .underflow(underflow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_empty();
        return fwft_mode ? !m_vld : (mq.size() == 0);
    endfunction

    function automatic int visible_cnt();
        return mq.size() + ((fwft_mode && m_vld) ? 1 : 0);
    endfunction

    task automatic model_step(input bit wr, input bit rd, input logic [WIDTH-1:0] din);
        bit full_p, mem_empty, wacc, fetch;
        full_p    = (mq.size() == DEPTH);
        mem_empty = (mq.size() == 0);
        wacc      = wr && !full_p;
        if (wr && full_p) m_ovf = 1'b1;
        if (!fwft_mode) begin
            if (rd && mem_empty) m_unf = 1'b1;
            if (rd && !mem_empty) begin
                m_od  = mq.pop_front();
                m_vld = 1'b1;
            end else begin
                m_vld = 1'b0;
            end
        end else begin
            if (rd && !m_vld) m_unf = 1'b1;
            fetch = !mem_empty && (!m_vld || rd);
            if (fetch) begin
                m_od  = mq.pop_front();
                m_vld = 1'b1;
            end else if (rd) begin
                m_vld = 1'b0;
            end
        end
        if (wacc) mq.push_back(din);
    endtask

    task automatic check_all();
        chk(fwft_mode ? "R7 full" : "R2 full", 32'(full), 32'(mq.size() == DEPTH));
        chk(fwft_mode ? "R5 empty" : "R10 empty", 32'(empty), 32'(exp_empty()));
        chk("R8 almost_full", 32'(almost_full), 32'(mq.size() >= int'(af_level)));
        chk("R9 almost_empty", 32'(almost_empty), 32'(visible_cnt() <= int'(ae_level)));
        chk(fwft_mode ? "R6 rd_valid" : "R3 rd_valid", 32'(rd_valid), 32'(m_vld));
        if (m_vld) chk(fwft_mode ? "R6 R11 rd_data" : "R3 R11 rd_data", 32'(rd_data), 32'(m_od));
        chk("R2 overflow", 32'(overflow), 32'(m_ovf));
        chk("R4 underflow", 32'(underflow), 32'(m_unf));
    endtask

    task automatic cycle(input bit wr, input bit rd, input logic [WIDTH-1:0] din);
        wr_en   = wr;
        rd_en   = rd;
        wr_data = din;
        model_step(wr, rd, din);
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst       = 1'b1;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        fwft_mode = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 empty in reset", 32'(empty), 32'd1);
        rst = 1'b0;
        mq.delete();
        m_vld = 1'b0;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        chk("R1 underflow", 32'(underflow), 32'd0);
    endtask

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            bit fill;
            fill = ((i / 40) % 2) == 0;
            if (i % 37 == 0) begin
                af_level = PW'($urandom_range(0, DEPTH));
                ae_level = PW'($urandom_range(0, DEPTH));
            end
            cycle(($urandom_range(0, 99) < (fill ? 80 : 25)),
                  ($urandom_range(0, 99) < (fill ? 25 : 80)),
                  WIDTH'($urandom));
        end
    endtask

    bit done = 1'b0;

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b0);
        // R10: single write into empty buffer, empty falls next cycle
        cycle(1, 0, 16'hA5A5);
        cycle(0, 1, '0);
        cycle(0, 0, '0);
        // R4: read while empty
        cycle(0, 1, '0);
        // R2: fill past full with overflow, then read+write while full
        for (int i = 0; i < DEPTH + 2; i++) cycle(1, 0, WIDTH'(16'h1000 + i));
        cycle(1, 1, 16'hBEEF);
        for (int i = 0; i < DEPTH + 3; i++) cycle(0, 1, '0);
        random_phase(500);

        do_reset(1'b1);
        // R5: first word shown without a read
        cycle(1, 0, 16'h5A5A);
        cycle(0, 0, '0);
        cycle(0, 0, '0);
        cycle(0, 1, '0);
        cycle(0, 1, '0);
        // R7: fill memory plus output word, overflow
        for (int i = 0; i < DEPTH + 3; i++) cycle(1, 0, WIDTH'(16'h2000 + i));
        // R6: back-to-back consumption
        for (int i = 0; i < DEPTH + 3; i++) cycle(0, 1, '0);
        random_phase(500);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule